// File: doc/BRIEF.md
# Pixel Hit Time and Charge Recorder

This block is the digital back end of a single detector pixel. It watches the discriminator output from the analog front end and, depending on the selected mode, records when a hit arrived and how long it stayed above threshold, or counts hits and their total time above threshold over an exposure window. Two clocks drive it. A reference clock captures a coarse timestamp from a chip-wide counter bus. A phase-aligned clock at sixteen times that rate measures the fraction of a reference period between the discriminator edge and the capturing reference edge.

The same two storage words serve every mode. In the timing modes the long word holds the coarse arrival time and the short word holds the time over threshold. In counting mode the short word counts hits and the long word integrates the reference cycles spent above threshold. A request flag tells the column logic that the words are ready. An acknowledge empties the pixel and re-arms it.

Top module: `pixel_hit_recorder`

## Requirements
- R1: While rst_n is low at a reference edge, and after release with no activity, word_long, word_short and fine_code are 0 and rd_req is 0.
- R2: In mode 2'b00 (arrival time plus duration) or 2'b01 (arrival time only), the first reference edge that samples disc high after it was sampled low loads word_long with the ts_bus value present at that edge. A later bus change does not alter it, and the value 16383 is held like any other.
- R3: In both timing modes, fine_code equals the number of fast clock rising edges after the disc rising edge, up to and including the capturing reference edge, saturating at 15. The value holds until acknowledge, whatever disc does in the meantime.
- R4: In mode 2'b00, word_short equals the number of consecutive reference edges that sample disc high, beginning with the capturing edge.
- R5: rd_req rises after reference edge C+19, where C is the capturing edge. In mode 2'b00, if disc is still high at that point, it rises after the first edge that samples disc low instead.
- R6: In mode 2'b01, word_short stays 0 and the request follows the 19-edge rule whatever the pulse length.
- R7: The duration count in word_short saturates at 1023 and does not wrap.
- R8: In mode 2'b10 (counting), while shutter is sampled high, word_short counts the edges where disc is sampled high after being low, and word_long counts the edges where disc is sampled high. fine_code stays 0. rd_req rises after the first edge that samples shutter low following an edge that sampled it high.
- R9: In mode 2'b10, word_short saturates at 1023 and word_long at 16383.
- R10: Once a hit is captured, further disc pulses before acknowledge change neither the words nor fine_code nor the request timing.
- R11: While mask is high, no capture or counting occurs. After any edge that samples mask high, rd_req and both words are 0.
- R12: An edge that samples ack high clears both words and rd_req, and fine_code returns to 0 within one fast clock period once disc is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock, timestamp rate |
| clk_fast | input | 1 | Fine clock, 16x reference, rising edges aligned to clk_ref |
| rst_n | input | 1 | Synchronous active-low reset, sampled on both clocks |
| mode | input | 2 | 00 arrival+duration, 01 arrival only, 10 counting, 11 idle |
| mask | input | 1 | Disables and clears the pixel |
| shutter | input | 1 | Exposure window for counting mode |
| ts_bus | input | 14 | Shared coarse timestamp |
| disc | input | 1 | Discriminator output |
| ack | input | 1 | Readout acknowledge, clears the pixel |
| word_long | output | 14 | Coarse arrival time or integrated time above threshold |
| word_short | output | 10 | Duration or hit count |
| fine_code | output | 4 | Fine arrival time |
| rd_req | output | 1 | Data ready for readout |

## Verification
A control state stuck outside idle shows up as a pixel that never raises its request again after the first acknowledge. A wrong age count moves the rising edge of rd_req away from edge C+19, so the very first hit exposes it at a single-cycle resolution. A fine counter whose gate opens at the wrong time shows up in fine_code as soon as the capturing edge passes, and keeps changing while the request is pending, which the next sample reveals. Counters that wrap instead of saturating show up only after 1024 or 16384 events, so those long runs are driven on purpose.

// File: rtl/pixrec_pkg.sv
// Shared types for the pixel hit recorder.
// Assumes the mode encoding is fixed by the column configuration.
package pixrec_pkg;

    typedef enum logic [1:0] {
        PXM_TIME_DUR  = 2'b00,
        PXM_TIME_ONLY = 2'b01,
        PXM_COUNT     = 2'b10,
        PXM_OFF       = 2'b11
    } pix_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_BUSY  = 2'b01,
        ST_READY = 2'b10
    } pix_state_e;

endpackage

// File: rtl/pixrec_fine_tdc.sv
// Fine arrival-time counter in the fast clock domain.
// Counts fast edges while the pixel is armed and disc is high, freezes while
// a capture is held, and clears otherwise. The count enable doubles as the
// oscillator gate, so nothing toggles outside a measurement.
// Assumes clk_fast rising edges coincide with clk_ref rising edges, so arm and
// hold, which come from the reference domain, are read without synchronizers.
module pixrec_fine_tdc #(
    parameter int FINE_W = 4
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              hold,
    input  logic              disc,
    output logic [FINE_W-1:0] fine_q
);
    localparam logic [FINE_W-1:0] FINE_MAX = '1;

    logic run;
    assign run = arm && disc;

    // Count, hold or clear the fine code on each fast edge.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            fine_q <= '0;
        end else if (run) begin
            if (fine_q != FINE_MAX) fine_q <= fine_q + 1'b1;
        end else if (!hold) begin
            fine_q <= '0;
        end
    end
endmodule

// File: rtl/pixrec_store.sv
// The two storage words shared by all modes.
// The long word is loaded from the timestamp bus or incremented. The short
// word is incremented. Both are cleared by a command that takes priority.
// A parameter selects saturating or wrapping increments.
module pixrec_store #(
    parameter int LONG_W   = 14,
    parameter int SHORT_W  = 10,
    parameter bit SATURATE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               ld_long,
    input  logic               inc_long,
    input  logic               inc_short,
    input  logic [LONG_W-1:0]  ts_in,
    output logic [LONG_W-1:0]  long_q,
    output logic [SHORT_W-1:0] short_q
);
    localparam logic [LONG_W-1:0]  LONG_MAX  = '1;
    localparam logic [SHORT_W-1:0] SHORT_MAX = '1;

    logic [LONG_W-1:0]  long_nx;
    logic [SHORT_W-1:0] short_nx;

    generate
        if (SATURATE) begin : g_sat
            assign long_nx  = (long_q  == LONG_MAX)  ? long_q  : long_q  + 1'b1;
            assign short_nx = (short_q == SHORT_MAX) ? short_q : short_q + 1'b1;
        end else begin : g_wrap
            assign long_nx  = long_q  + 1'b1;
            assign short_nx = short_q + 1'b1;
        end
    endgenerate

    // Long word: clear, load a timestamp, or accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  long_q <= '0;
        else if (ld_long)   long_q <= ts_in;
        else if (inc_long)  long_q <= long_nx;
    end

    // Short word: clear or accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  short_q <= '0;
        else if (inc_short) short_q <= short_nx;
    end
endmodule

// File: rtl/pixrec_ctrl.sv
// Reference-domain control for the pixel.
// Detects disc and shutter edges, runs the capture / wait / ready sequence in
// the timing modes and the exposure counting in counting mode, and issues
// commands to the storage words. mask and ack both force the idle state.
// Assumes disc pulses span at least one reference edge and that mode is
// changed only while the pixel is idle.
module pixrec_ctrl
    import pixrec_pkg::*;
#(
    parameter int RO_DELAY = 19
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pix_mode_e mode,
    input  logic      mask,
    input  logic      shutter,
    input  logic      disc,
    input  logic      ack,
    output logic      clr,
    output logic      ld_long,
    output logic      inc_long,
    output logic      inc_short,
    output logic      fine_arm,
    output logic      fine_hold,
    output logic      rd_req
);
    localparam int AGE_W = $clog2(RO_DELAY + 1);
    localparam logic [AGE_W-1:0] AGE_END = AGE_W'(RO_DELAY);

    pix_state_e       st_q, st_n;
    logic [AGE_W-1:0] age_q, age_n;
    logic             dur_q, dur_n;
    logic             disc_q, shut_q;
    logic             rise, timing_mode, count_mode;

    assign rise        = disc && !disc_q;
    assign timing_mode = (mode == PXM_TIME_DUR) || (mode == PXM_TIME_ONLY);
    assign count_mode  = (mode == PXM_COUNT);

    // Next-state and command decode.
    always_comb begin
        st_n      = st_q;
        age_n     = age_q;
        dur_n     = dur_q;
        clr       = 1'b0;
        ld_long   = 1'b0;
        inc_long  = 1'b0;
        inc_short = 1'b0;
        if (ack || mask) begin
            clr   = 1'b1;
            st_n  = ST_IDLE;
            age_n = '0;
            dur_n = 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (timing_mode && rise) begin
                        ld_long = 1'b1;
                        st_n    = ST_BUSY;
                        age_n   = '0;
                        if (mode == PXM_TIME_DUR) begin
                            inc_short = 1'b1;
                            dur_n     = 1'b1;
                        end
                    end else if (count_mode) begin
                        if (shutter) begin
                            inc_short = rise;
                            inc_long  = disc;
                        end else if (shut_q) begin
                            st_n = ST_READY;
                        end
                    end
                end
                ST_BUSY: begin
                    age_n = (age_q == AGE_END) ? age_q : age_q + 1'b1;
                    dur_n = dur_q && disc;
                    inc_short = dur_q && disc;
                    if (age_n == AGE_END && !dur_n) st_n = ST_READY;
                end
                default: begin
                    st_n = ST_READY;
                end
            endcase
        end
    end

    // State, hit age and duration-active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            age_q <= '0;
            dur_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            age_q <= age_n;
            dur_q <= dur_n;
        end
    end

    // Previous samples of disc and shutter for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disc_q <= 1'b0;
            shut_q <= 1'b0;
        end else begin
            disc_q <= disc;
            shut_q <= shutter;
        end
    end

    assign rd_req    = (st_q == ST_READY);
    assign fine_arm  = (st_q == ST_IDLE) && timing_mode && !mask;
    assign fine_hold = (st_q != ST_IDLE) && timing_mode && !mask;
endmodule

// File: rtl/pixel_hit_recorder.sv
// Per-pixel digital recorder: arrival time, duration, or hit counting.
// Ties the control sequencer, the shared storage words and the fine-time
// counter together. Assumes clk_fast is clk_ref times 2**FINE_W with aligned
// rising edges and that disc is already free of glitches shorter than one
// fast period.
module pixel_hit_recorder #(
    parameter int TS_W     = 14,
    parameter int DUR_W    = 10,
    parameter int FINE_W   = 4,
    parameter int RO_DELAY = 19
) (
    input  logic              clk_ref,
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              mask,
    input  logic              shutter,
    input  logic [TS_W-1:0]   ts_bus,
    input  logic              disc,
    input  logic              ack,
    output logic [TS_W-1:0]   word_long,
    output logic [DUR_W-1:0]  word_short,
    output logic [FINE_W-1:0] fine_code,
    output logic              rd_req
);
    import pixrec_pkg::*;

    logic clr, ld_long, inc_long, inc_short, fine_arm, fine_hold;
    pix_mode_e mode_e;

    assign mode_e = pix_mode_e'(mode);

    pixrec_ctrl #(
        .RO_DELAY (RO_DELAY)
    ) u_ctrl (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .mode      (mode_e),
        .mask      (mask),
        .shutter   (shutter),
        .disc      (disc),
        .ack       (ack),
        .clr       (clr),
        .ld_long   (ld_long),
        .inc_long  (inc_long),
        .inc_short (inc_short),
        .fine_arm  (fine_arm),
        .fine_hold (fine_hold),
        .rd_req    (rd_req)
    );

    pixrec_store #(
        .LONG_W   (TS_W),
        .SHORT_W  (DUR_W),
        .SATURATE (1'b1)
    ) u_store (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .clr       (clr),
        .ld_long   (ld_long),
        .inc_long  (inc_long),
        .inc_short (inc_short),
        .ts_in     (ts_bus),
        .long_q    (word_long),
        .short_q   (word_short)
    );

    pixrec_fine_tdc #(
        .FINE_W (FINE_W)
    ) u_fine (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .arm      (fine_arm),
        .hold     (fine_hold),
        .disc     (disc),
        .fine_q   (fine_code)
    );
endmodule

// File: rtl/pixrec_checker.sv
// Port-level properties of the pixel hit recorder, bound to the top module.
// Assumes rst_n is low at the first reference edge.
module pixrec_checker #(
    parameter int TS_W  = 14,
    parameter int DUR_W = 10
) (
    input logic             clk_ref,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             mask,
    input logic             ack,
    input logic [TS_W-1:0]  word_long,
    input logic [DUR_W-1:0] word_short,
    input logic             rd_req
);
    localparam logic [TS_W-1:0]  L_MAX = '1;
    localparam logic [DUR_W-1:0] S_MAX = '1;

    a_r11_mask_clears: assert property (@(posedge clk_ref) disable iff (!rst_n)
        mask |=> (!rd_req && word_long == '0 && word_short == '0));

    a_r12_ack_clears: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ack |=> (!rd_req && word_long == '0 && word_short == '0));

    a_r10_pending_held: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (rd_req && !ack && !mask) |=> (rd_req && $stable(word_long) && $stable(word_short)));

    a_r7_short_saturates: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (word_short == S_MAX && !ack && !mask) |=> (word_short == S_MAX));

    a_r9_long_saturates: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (mode == 2'b10 && word_long == L_MAX && !ack && !mask) |=> (word_long == L_MAX));

    a_r5_req_unmasked: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(rd_req) |-> $past(!ack && !mask));
endmodule

bind pixel_hit_recorder pixrec_checker #(
    .TS_W  (TS_W),
    .DUR_W (DUR_W)
) u_pixrec_checker (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .mode       (mode),
    .mask       (mask),
    .ack        (ack),
    .word_long  (word_long),
    .word_short (word_short),
    .rd_req     (rd_req)
);

// File: tb/tb_pixel_hit_recorder.sv
`timescale 1ns/1ps
module tb_pixel_hit_recorder;
    logic        clk_ref = 1'b0, clk_fast = 1'b0, rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        mask = 1'b0, shutter = 1'b0, disc = 1'b0, ack = 1'b0;
    logic [13:0] ts_bus = '0;
    logic [13:0] word_long;
    logic [9:0]  word_short;
    logic [3:0]  fine_code;
    logic        rd_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    pixel_hit_recorder dut (
        .clk_ref(clk_ref), .clk_fast(clk_fast), .rst_n(rst_n), .mode(mode),
        .mask(mask), .shutter(shutter), .ts_bus(ts_bus), .disc(disc), .ack(ack),
        .word_long(word_long), .word_short(word_short), .fine_code(fine_code),
        .rd_req(rd_req)
    );

    // 50 MHz reference and 800 MHz fine clock with aligned rising edges.
    initial begin
        int tog = 0;
        forever begin
            #0.625;
            tog++;
            clk_fast = ~clk_fast;
            if (tog % 16 == 1) clk_ref = ~clk_ref;
        end
    end

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Columns: mode, ts, rise-before-edge (ps), edges high, exp long, exp fine,
    // exp short, exp request edge, second pulse on, second pulse off.
    localparam int NV = 9;
    localparam int TBL [NV][10] = '{
        '{0, 16383,  5300,    4, 16383,  5,    4,   19, 0, 0},
        '{0,  1234,   600,    1,  1234,  1,    1,   19, 0, 0},
        '{1,   777, 10100,    6,   777,  9,    0,   19, 0, 0},
        '{0,    42, 19300,   25,    42, 15,   25,   25, 0, 0},
        '{1,     0, 12600,   30,     0, 11,    0,   19, 0, 0},
        '{0,  9000,  3800,   19,  9000,  4,   19,   19, 0, 0},
        '{0,  5000,  8000,   20,  5000,  7,   20,   20, 0, 0},
        '{0,   300,  5300,    3,   300,  5,    3,   19, 5, 8},
        '{0,    50,  5300, 1100,    50,  5, 1023, 1100, 0, 0}
    };

    // Drive one hit and return the edge count at which rd_req was first seen.
    task automatic run_hit(int md, int ts, int rise_ps, int hi, int s_on, int s_off,
                           output int reqn);
        int n = 0;
        reqn = -1;
        @(posedge clk_ref);
        #0.5;
        mode = 2'(md);
        ts_bus = 14'(ts);
        #(19.5 - rise_ps / 1000.0);
        disc = 1'b1;
        @(posedge clk_ref);
        #2;
        ts_bus = 14'((ts + 1) % 16384);
        if (hi == 1) disc = 1'b0;
        while (n < 2000 && reqn < 0) begin
            @(posedge clk_ref);
            n++;
            #2;
            if (n == hi - 1) disc = 1'b0;
            if (n == s_on) begin disc = 1'b1; ts_bus = 14'd999; end
            if (n == s_off) disc = 1'b0;
            if (rd_req) reqn = n;
        end
        disc = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(posedge clk_ref);
        #2;
        ack = 1'b0;
    endtask

    task automatic pulse(int hi, int gap);
        disc = 1'b1;
        repeat (hi) @(posedge clk_ref);
        #2;
        disc = 1'b0;
        repeat (gap) @(posedge clk_ref);
        #2;
    endtask

    initial begin
        #(20.0 * 200000);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        int reqn;
        // R1: reset state
        repeat (4) @(posedge clk_ref);
        #2;
        check("R1 req in reset", int'(rd_req), 0);
        check("R1 long in reset", int'(word_long), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk_ref);
        #2;
        check("R1 short after reset", int'(word_short), 0);
        check("R1 fine after reset", int'(fine_code), 0);
        check("R1 req after reset", int'(rd_req), 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R10 R12
        for (int i = 0; i < NV; i++) begin
            run_hit(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3], TBL[i][8], TBL[i][9], reqn);
            check($sformatf("R2 coarse row %0d", i), int'(word_long), TBL[i][4]);
            check($sformatf("R3 fine row %0d", i), int'(fine_code), TBL[i][5]);
            check($sformatf("R4 R6 R7 R10 short row %0d", i), int'(word_short), TBL[i][6]);
            check($sformatf("R5 request edge row %0d", i), reqn, TBL[i][7]);
            do_ack();
            check($sformatf("R12 cleared row %0d", i),
                  int'(word_long) + int'(word_short) + int'(fine_code) + int'(rd_req), 0);
        end

        // R11: masked pixel ignores a hit
        mask = 1'b1;
        run_hit(0, 4321, 5300, 4, 0, 0, reqn);
        check("R11 no request", reqn, -1);
        check("R11 long", int'(word_long), 0);
        check("R11 short", int'(word_short), 0);
        check("R11 fine", int'(fine_code), 0);
        mask = 1'b0;

        // R8: counting mode with shutter gating
        mode = 2'b10;
        pulse(3, 2);
        shutter = 1'b1;
        @(posedge clk_ref);
        #2;
        pulse(2, 2);
        pulse(5, 1);
        pulse(1, 3);
        shutter = 1'b0;
        check("R8 no request while open", int'(rd_req), 0);
        @(posedge clk_ref);
        #2;
        check("R8 request after close", int'(rd_req), 1);
        check("R8 hit count", int'(word_short), 3);
        check("R8 time above threshold", int'(word_long), 8);
        check("R8 fine idle", int'(fine_code), 0);
        do_ack();

        // R9: counting mode saturation
        shutter = 1'b1;
        @(posedge clk_ref);
        #2;
        pulse(16400, 1);
        for (int k = 0; k < 1030; k++) pulse(1, 1);
        shutter = 1'b0;
        @(posedge clk_ref);
        #2;
        check("R9 count saturates", int'(word_short), 1023);
        check("R9 integral saturates", int'(word_long), 16383);
        check("R9 request", int'(rd_req), 1);
        do_ack();
        check("R12 cleared after count", int'(word_long) + int'(word_short), 0);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end
endmodule